// File: doc/BRIEF.md
# Two-Sample Running Average Filter

This block sits behind a converter core and conditions its stream of signed conversion results. Each time the core presents a raw result, the filter produces one output result a clock later. In double-rate mode the output is the mean of the newest raw result and the one before it. Averaging two results removes offset and drift that alternate between them, and every raw result still yields an output. In single-rate mode each raw result passes through unchanged.

Along with the core's data, the filter receives the configuration that produced it: the input channel, the speed/resolution code and the rate mode bit. It compares that configuration with the one that went with the previous raw result, and raises a validity flag on each output. A new channel costs exactly one invalid output. A new speed code keeps the output valid. Toggling the rate mode alone keeps the output valid.

Top module: `pair_mean_filter`

## Requirements
- R1: While reset is asserted and right after it is released, out_stb, out_valid and out_data are all zero.
- R2: out_stb is high for exactly one clock, in the cycle after each cycle in which raw_vld is high, and low otherwise.
- R3: With cfg_dbl = 0 (single-rate), out_data equals the raw_data that came with the strobe.
- R4: With cfg_dbl = 1 (double-rate) and a previous raw result held since reset, out_data is floor((previous + current)/2). The sum is formed with one extra bit, so full-scale inputs do not overflow. The previous result is the one from the last strobe, whatever mode it arrived in.
- R5: The first raw result after reset, if it arrives in double-rate mode, gives out_valid = 0 and out_data equal to that raw result.
- R6: When cfg_chan differs from the channel of the previous raw result, that output has out_valid = 0. The next output on the same channel has out_valid = 1.
- R7: When only cfg_speed differs from the previous raw result's speed code, the output has out_valid = 1.
- R8: When only cfg_dbl differs from the previous raw result's mode, the output has out_valid = 1, and the data follows the new mode.
- R9: Between strobes, out_data and out_valid hold their values. Configuration changes made while raw_vld is low have no effect: only the configuration present at each strobe is compared.
- R10: The first raw result after reset in single-rate mode gives out_valid = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_vld | input | 1 | Raw result strobe from the converter core |
| raw_data | input | DW | Signed raw conversion result |
| cfg_chan | input | CW | Input channel used for this result |
| cfg_speed | input | SW | Speed/resolution code used for this result |
| cfg_dbl | input | 1 | 1 = double-rate averaging, 0 = single-rate pass-through |
| out_data | output | DW | Filtered signed result |
| out_valid | output | 1 | Output result is trustworthy |
| out_stb | output | 1 | One-cycle pulse marking a new output |

## Verification
The hardest condition to reach is a configuration change that occurs between strobes. The filter must ignore it, because it only compares the configuration present at strobe instants. The bench switches the channel away while raw_vld is low and switches it back before the next strobe, then expects a valid output. A second hard case is floor rounding at full scale. For this the bench drives pairs at the positive and negative limits and a negative odd sum in double-rate mode.

// File: rtl/pair_mean_filter.sv
module pair_mean_filter #(
  parameter int DW = 24,
  parameter int CW = 4,
  parameter int SW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 raw_vld,
  input  logic signed [DW-1:0] raw_data,
  input  logic        [CW-1:0] cfg_chan,
  input  logic        [SW-1:0] cfg_speed,
  input  logic                 cfg_dbl,
  output logic signed [DW-1:0] out_data,
  output logic                 out_valid,
  output logic                 out_stb
);

  logic                 seen;
  logic [CW-1:0]        last_chan;
  logic [SW-1:0]        last_speed;
  logic signed [DW-1:0] prev;
  logic signed [DW:0]   sum;

  assign sum = {prev[DW-1], prev} + {raw_data[DW-1], raw_data};

  wire chan_moved = seen && (cfg_chan != last_chan);
  wire no_hist    = cfg_dbl && !seen;
  wire use_mean   = cfg_dbl && seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen       <= 1'b0;
      last_chan  <= '0;
      last_speed <= '0;
      prev       <= '0;
      out_data   <= '0;
      out_valid  <= 1'b0;
      out_stb    <= 1'b0;
    end else begin
      out_stb <= raw_vld;
      if (raw_vld) begin
        seen       <= 1'b1;
        last_chan  <= cfg_chan;
        last_speed <= cfg_speed;
        prev       <= raw_data;
        out_data   <= use_mean ? sum[DW:1] : raw_data;
        out_valid  <= !(chan_moved || no_hist);
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_stb |-> ($stable(out_data) && $stable(out_valid)));

  p_chan_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_vld && seen && cfg_chan != last_chan) |=> (out_stb && !out_valid));

  p_speed_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_vld && seen && cfg_chan == last_chan && cfg_speed != last_speed) |=> out_valid);

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_vld && !cfg_dbl) |=> (out_data == $past(raw_data)));

  p_mean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_vld && cfg_dbl && seen) |=>
      (($past(sum) == {out_data, 1'b0}) || ($past(sum) == {out_data, 1'b1})));

  p_empty_hist_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_vld && cfg_dbl && !seen) |=> (!out_valid && out_data == $past(raw_data)));

endmodule

// File: tb/sim_pair_mean_filter.sv
`timescale 1ns/1ps
module sim_pair_mean_filter;
  localparam int DW = 24, CW = 4, SW = 5;

  logic clk = 1'b0, rst_n = 1'b0, raw_vld = 1'b0, cfg_dbl = 1'b0;
  logic signed [DW-1:0] raw_data = '0;
  logic [CW-1:0] cfg_chan = '0;
  logic [SW-1:0] cfg_speed = '0;
  logic signed [DW-1:0] out_data;
  logic out_valid, out_stb;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pair_mean_filter #(.DW(DW), .CW(CW), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .raw_vld(raw_vld), .raw_data(raw_data),
    .cfg_chan(cfg_chan), .cfg_speed(cfg_speed), .cfg_dbl(cfg_dbl),
    .out_data(out_data), .out_valid(out_valid), .out_stb(out_stb));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; raw_vld = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic signed [DW-1:0] d, input logic [CW-1:0] ch,
                      input logic [SW-1:0] sp, input logic dbl,
                      input longint exp_d, input bit exp_v, input string req);
    @(negedge clk);
    raw_data = d; cfg_chan = ch; cfg_speed = sp; cfg_dbl = dbl; raw_vld = 1'b1;
    @(negedge clk);
    raw_vld = 1'b0;
    chk(out_stb == 1'b1, "R2", longint'(out_stb), 1);
    chk(longint'(out_data) == exp_d, req, longint'(out_data), exp_d);
    chk(out_valid == exp_v, req, longint'(out_valid), longint'(exp_v));
    @(negedge clk);
    chk(out_stb == 1'b0, "R2", longint'(out_stb), 0);
  endtask

  task automatic t_reset();
    chk(out_stb == 0 && out_valid == 0 && out_data == 0, "R1",
        longint'({out_stb, out_valid, out_data}), 0);
    do_reset();
    chk(out_stb == 0 && out_valid == 0 && out_data == 0, "R1",
        longint'({out_stb, out_valid, out_data}), 0);
  endtask

  task automatic t_single();
    do_reset();
    push(24'sd1000, 4'd1, 5'd3, 1'b0, 1000, 1'b1, "R10");
    push(-24'sd77, 4'd1, 5'd3, 1'b0, -77, 1'b1, "R3");
    push(24'sd5, 4'd1, 5'd3, 1'b0, 5, 1'b1, "R3");
  endtask

  task automatic t_double();
    do_reset();
    push(24'sd5, 4'd2, 5'd1, 1'b1, 5, 1'b0, "R5");
    push(24'sd2, 4'd2, 5'd1, 1'b1, 3, 1'b1, "R4");
    push(-24'sd5, 4'd2, 5'd1, 1'b1, -2, 1'b1, "R4");
    push(24'sd2, 4'd2, 5'd1, 1'b1, -2, 1'b1, "R4");
    push(24'sh7FFFFF, 4'd2, 5'd1, 1'b1, 4194304, 1'b1, "R4");
    push(24'sh7FFFFF, 4'd2, 5'd1, 1'b1, 8388607, 1'b1, "R4");
    push(-24'sd8388607, 4'd2, 5'd1, 1'b1, 0, 1'b1, "R4");
    push(-24'sd8388608, 4'd2, 5'd1, 1'b1, -8388608, 1'b1, "R4");
  endtask

  task automatic t_chan();
    do_reset();
    push(24'sd100, 4'd3, 5'd2, 1'b1, 100, 1'b0, "R5");
    push(24'sd200, 4'd3, 5'd2, 1'b1, 150, 1'b1, "R4");
    push(24'sd400, 4'd4, 5'd2, 1'b1, 300, 1'b0, "R6");
    push(24'sd600, 4'd4, 5'd2, 1'b1, 500, 1'b1, "R6");
    push(24'sd10, 4'd5, 5'd2, 1'b0, 10, 1'b0, "R6");
    push(24'sd11, 4'd5, 5'd2, 1'b0, 11, 1'b1, "R6");
  endtask

  task automatic t_speed_mode();
    do_reset();
    push(24'sd40, 4'd1, 5'd0, 1'b1, 40, 1'b0, "R5");
    push(24'sd60, 4'd1, 5'd9, 1'b1, 50, 1'b1, "R7");
    push(24'sd80, 4'd1, 5'd9, 1'b0, 80, 1'b1, "R8");
    push(24'sd20, 4'd1, 5'd9, 1'b1, 50, 1'b1, "R8");
    push(24'sd30, 4'd1, 5'd4, 1'b0, 30, 1'b1, "R7");
  endtask

  task automatic t_idle_cfg();
    do_reset();
    push(24'sd8, 4'd6, 5'd1, 1'b0, 8, 1'b1, "R10");
    @(negedge clk);
    cfg_chan = 4'd9; cfg_speed = 5'd20; cfg_dbl = 1'b1; raw_data = 24'sd999;
    repeat (3) @(negedge clk);
    chk(out_data == 8 && out_valid == 1'b1 && out_stb == 1'b0, "R9",
        longint'(out_data), 8);
    push(24'sd12, 4'd6, 5'd1, 1'b0, 12, 1'b1, "R9");
  endtask

  initial begin
    #1;
    t_reset();
    t_single();
    t_double();
    t_chan();
    t_speed_mode();
    t_idle_cfg();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule